// File: doc/BRIEF.md
# Rotate-and-Mask Datapath Unit

This unit turns a 32-bit word left by a 5-bit amount, builds a contiguous run of ones from a begin offset and an end offset, and merges the turned word with that run. Two merge modes exist. The clear mode keeps rotated bits under the run and zeroes the rest. The insert mode takes rotated bits under the run and keeps the bits of a previous destination word elsewhere. Together these give rotate-and-mask and bit-field insert operations for an integer pipeline stage.

Offsets use big-endian numbering. Offset 0 is the most significant bit (vector bit 31) and offset 31 is the least significant bit (vector bit 0). When the begin offset is greater than the end offset, the run of ones wraps across the word boundary. Because of this, every begin/end pair yields at least one set bit. A strobe qualifies each operation. The result and its valid flag appear one clock later.

Top module: `rotmask_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` is 1, and is 0 otherwise.
- R3: The rotation moves bits toward the most significant end by `amount` (0 to 31), and bits leaving bit 31 re-enter at bit 0. An amount of 0 leaves the word unchanged.
- R4: When `mask_begin` is not greater than `mask_end`, the mask has ones exactly at offsets `mask_begin` through `mask_end` inclusive. Offset k is vector bit 31-k.
- R5: When `mask_begin` is greater than `mask_end`, the mask has ones at offsets `mask_begin` through 31 and at offsets 0 through `mask_end`.
- R6: Equal offsets give exactly one set bit. No offset pair gives an all-zero mask: the mask population is `mask_end-mask_begin+1` when not wrapping, and `33-mask_begin+mask_end` when wrapping.
- R7: With `op_insert`=0, `result` is the rotated word ANDed with the mask.
- R8: With `op_insert`=1, `result` takes rotated bits where the mask is 1 and `dst_prev` bits where the mask is 0.
- R9: In a cycle with `in_valid`=0, input changes have no effect, and `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_insert | input | 1 | 0: AND with mask, 1: insert under mask |
| src | input | 32 | Word to rotate |
| dst_prev | input | 32 | Previous destination word for insert |
| amount | input | 5 | Left rotate amount |
| mask_begin | input | 5 | Begin offset of the ones run (0 = MSB) |
| mask_end | input | 5 | End offset of the ones run |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| result | output | 32 | Registered merged result |

## Verification
On every cycle, the assertions check the one-cycle valid timing, the hold of `result` between strobes, and a few merge identities. These identities are: a zero source clears the clear-mode result, an all-ones source never yields zero, a full mask with no rotation is a pass-through, and insert of a word into itself is that word. The exact rotated values and the placement of the ones run, including every wrapping begin/end pair, are shown only by the bench. It uses its table of hand-worked vectors and a sweep over all 1024 offset pairs that counts the mask population.

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          op_insert,
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  dst_prev,
  input  logic [AW-1:0] amount,
  input  logic [AW-1:0] mask_begin,
  input  logic [AW-1:0] mask_end,
  output logic          out_valid,
  output logic [W-1:0]  result
);
  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot, mask, merged;
  logic           wraps;

  assign dbl   = {src, src} << amount;
  assign rot   = dbl[2*W-1:W];
  assign wraps = mask_begin > mask_end;

  for (genvar i = 0; i < W; i++) begin : g_mask
    localparam logic [AW-1:0] OFS = AW'(W - 1 - i);
    logic ge_b, le_e;
    assign ge_b    = OFS >= mask_begin;
    assign le_e    = OFS <= mask_end;
    assign mask[i] = wraps ? (ge_b | le_e) : (ge_b & le_e);
  end

  assign merged = op_insert ? ((rot & mask) | (dst_prev & ~mask)) : (rot & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end
endmodule

module rotmask_unit_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          op_insert,
  input logic [W-1:0]  src,
  input logic [W-1:0]  dst_prev,
  input logic [AW-1:0] amount,
  input logic [AW-1:0] mask_begin,
  input logic [AW-1:0] mask_end,
  input logic          out_valid,
  input logic [W-1:0]  result
);
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_zero_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert && src == '0) |=> result == '0);
  p_never_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert && src == '1) |=> result != '0);
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert && amount == '0 && mask_begin == '0 && mask_end == AW'(W-1))
    |=> result == $past(src));
  p_self_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_insert && amount == '0 && src == dst_prev) |=> result == $past(src));
endmodule

bind rotmask_unit rotmask_unit_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_insert = 1'b0;
  logic [31:0] src = '0, dst_prev = '0;
  logic [4:0]  amount = '0, mask_begin = '0, mask_end = '0;
  logic        out_valid;
  logic [31:0] result;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  rotmask_unit u_dut (.*);

  typedef struct packed {
    logic        op;
    logic [4:0]  amt, mb, me;
    logic [31:0] s, d, e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  5'd0,  5'd31, 32'h12345678, 32'h0,        32'h12345678, 4'd3}, // R3
    '{1'b0, 5'd4,  5'd0,  5'd31, 32'h12345678, 32'h0,        32'h23456781, 4'd3}, // R3
    '{1'b0, 5'd8,  5'd0,  5'd31, 32'hDEADBEEF, 32'h0,        32'hADBEEFDE, 4'd3}, // R3
    '{1'b0, 5'd31, 5'd0,  5'd31, 32'h00000001, 32'h0,        32'h80000000, 4'd3}, // R3
    '{1'b0, 5'd1,  5'd0,  5'd31, 32'h80000000, 32'h0,        32'h00000001, 4'd3}, // R3
    '{1'b0, 5'd0,  5'd0,  5'd7,  32'hFFFFFFFF, 32'h0,        32'hFF000000, 4'd4}, // R4
    '{1'b0, 5'd0,  5'd28, 5'd3,  32'hFFFFFFFF, 32'h0,        32'hF000000F, 4'd5}, // R5
    '{1'b0, 5'd0,  5'd5,  5'd5,  32'hFFFFFFFF, 32'h0,        32'h04000000, 4'd6}, // R6
    '{1'b1, 5'd0,  5'd8,  5'd15, 32'hAAAAAAAA, 32'h55555555, 32'h55AA5555, 4'd8}, // R8
    '{1'b1, 5'd16, 5'd0,  5'd15, 32'h0000BEEF, 32'h12345678, 32'hBEEF5678, 4'd8}, // R8
    '{1'b1, 5'd0,  5'd31, 5'd0,  32'hFFFFFFFF, 32'h00000000, 32'h80000001, 4'd5}  // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic op, input logic [4:0] amt, input logic [4:0] mb,
                     input logic [4:0] me, input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; op_insert = op; amount = amt;
    mask_begin = mb; mask_end = me; src = s; dst_prev = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
    check("R1 result in reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out_valid after reset", {31'b0, out_valid}, 32'h0);
    check("R1 result after reset", result, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].op, VECS[i].amt, VECS[i].mb, VECS[i].me, VECS[i].s, VECS[i].d);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].e);
      check("R2 out_valid after strobe", {31'b0, out_valid}, 32'h1);
    end

    // R7: clear mode drops bits outside the mask
    run(1'b0, 5'd0, 5'd8, 5'd15, 32'hAAAAAAAA, 32'hFFFFFFFF);
    check("R7 clear mode ignores dst_prev", result, 32'h00AA0000);

    // R9: idle-cycle input changes leave result alone
    @(negedge clk);
    src = 32'hFFFFFFFF; mask_begin = 5'd0; mask_end = 5'd31; op_insert = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 result held while idle", result, 32'h00AA0000);
    check("R2 out_valid low while idle", {31'b0, out_valid}, 32'h0);

    // R4 R5 R6: population sweep over every begin/end pair
    for (int b = 0; b < 32; b++) begin
      for (int e = 0; e < 32; e++) begin
        int pop;
        pop = (b <= e) ? (e - b + 1) : (33 - b + e);
        run(1'b0, 5'd0, 5'(b), 5'(e), 32'hFFFFFFFF, 32'h0);
        check($sformatf("R6 popcount b=%0d e=%0d", b, e), 32'($countones(result)), 32'(pop));
        check($sformatf("R4 R5 begin bit b=%0d e=%0d", b, e), {31'b0, result[31-b]}, 32'h1);
        check($sformatf("R4 R5 end bit b=%0d e=%0d", b, e), {31'b0, result[31-e]}, 32'h1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule